// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block gathers the three interrupt causes of a UART and presents them as a 3-bit pending mask. Each cause has its own bit: bit 2 is a receive line fault (overrun, parity, framing or break), bit 1 is receive data available, and bit 0 is transmit holding register empty. Because each cause owns a bit, several causes can be pending together. For example, a mask of 101 means a line fault and an empty transmit holder are both waiting.

A bit is set by a one-cycle event pulse from the receiver or transmitter, but only while that cause is enabled. Each bit is cleared by the register access that belongs to its cause: a read of the line status register, a read of the receive buffer, or a read of the identification register / write of the transmit holder. The block also reports the highest-priority pending cause as an encoded value and drives one interrupt request line.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, the pending mask `pend_id` is 000, `top_src` is 00 and `irq` is 0.
- R2: An event pulse on `ev_lerr` with `en_lerr` high sets `pend_id[2]` on the next clock edge. A `rd_lsr` strobe without a simultaneous event clears it on the next edge.
- R3: An event pulse on `ev_rxrdy` with `en_rxrdy` high sets `pend_id[1]`. A `rd_rbr` strobe without a simultaneous event clears it.
- R4: An event pulse on `ev_thre` with `en_thre` high sets `pend_id[0]`. Either `rd_iid` or `wr_thr` without a simultaneous event clears it.
- R5: A strobe clears only its own bit. Other pending bits keep their value.
- R6: When a set event and its clear strobe arrive in the same cycle, the bit is set (or stays set) after that edge.
- R7: An event on a cause whose enable is low leaves that bit unchanged.
- R8: `irq` is high exactly when some bit of `pend_id` is set and its enable is high. The mask relation is combinational.
- R9: `top_src` encodes the highest set bit of `pend_id`, and it ignores the enables. The encoding is 11 for bit 2, 10 for bit 1, 01 for bit 0 only, and 00 when nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_lerr | input | 1 | Line fault event pulse |
| ev_rxrdy | input | 1 | Receive data ready event pulse |
| ev_thre | input | 1 | Transmit holder empty event pulse |
| en_lerr | input | 1 | Enable for line fault cause |
| en_rxrdy | input | 1 | Enable for receive ready cause |
| en_thre | input | 1 | Enable for transmit empty cause |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_rbr | input | 1 | Receive buffer read strobe |
| rd_iid | input | 1 | Identification register read strobe |
| wr_thr | input | 1 | Transmit holder write strobe |
| pend_id | output | 3 | Pending cause mask, bit 2 line fault, bit 1 rx ready, bit 0 tx empty |
| top_src | output | 2 | Encoded highest-priority pending cause |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every combination of the starting mask, the three events, the three enables and the four strobes, and compares each outcome against a mask computed arithmetically in the bench.

Each corner case has a typical failure it catches:
- **Set and clear in the same cycle:** a design that let clear win would drop a real event.
- **Clear crosstalk:** a design that wired one strobe to the wrong bit would wipe out an unrelated pending cause.
- **Disabled events:** a design that ignored the enables on set would raise bits that should stay low.
- **Priority encode:** a design whose encoder had the wrong order would name a lower cause ahead of a line fault.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_lerr,
  input  logic       ev_rxrdy,
  input  logic       ev_thre,
  input  logic       en_lerr,
  input  logic       en_rxrdy,
  input  logic       en_thre,
  input  logic       rd_lsr,
  input  logic       rd_rbr,
  input  logic       rd_iid,
  input  logic       wr_thr,
  output logic [2:0] pend_id,
  output logic [1:0] top_src,
  output logic       irq
);
  logic [2:0] set_v, clr_v, en_v;

  assign en_v  = {en_lerr, en_rxrdy, en_thre};
  assign set_v = {ev_lerr, ev_rxrdy, ev_thre} & en_v;
  assign clr_v = {rd_lsr, rd_rbr, rd_iid | wr_thr};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_id <= 3'b000;
    else        pend_id <= set_v | (pend_id & ~clr_v);

  assign irq = |(pend_id & en_v);

  always_comb begin
    if (pend_id[2])      top_src = 2'd3;
    else if (pend_id[1]) top_src = 2'd2;
    else if (pend_id[0]) top_src = 2'd1;
    else                 top_src = 2'd0;
  end

  a_r2_lerr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_lerr && en_lerr) |=> pend_id[2]);
  a_r3_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rbr && !(ev_rxrdy && en_rxrdy)) |=> !pend_id[1]);
  a_r4_thre_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_iid || wr_thr) && !(ev_thre && en_thre)) |=> !pend_id[0]);
  a_r7_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_lerr && !rd_lsr) |=> $stable(pend_id[2]));
  a_r9_top_line: assert property (@(posedge clk) disable iff (!rst_n)
    pend_id[2] |-> top_src == 2'd3);
  a_r8_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_id == 3'b000) |-> !irq);
endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  logic clk = 0, rst_n = 0;
  logic ev_lerr = 0, ev_rxrdy = 0, ev_thre = 0;
  logic en_lerr = 0, en_rxrdy = 0, en_thre = 0;
  logic rd_lsr = 0, rd_rbr = 0, rd_iid = 0, wr_thr = 0;
  logic [2:0] pend_id;
  logic [1:0] top_src;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_ident u_uart_irq_ident (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] ev, logic [2:0] en, logic [3:0] st);
    {ev_lerr, ev_rxrdy, ev_thre} = ev;
    {en_lerr, en_rxrdy, en_thre} = en;
    {rd_lsr, rd_rbr, rd_iid, wr_thr} = st;
  endtask

  function automatic int prio(logic [2:0] m);
    return m[2] ? 3 : m[1] ? 2 : m[0] ? 1 : 0;
  endfunction

  task automatic load(logic [2:0] m);
    @(negedge clk); drive(3'b000, 3'b000, 4'b1111);
    @(negedge clk); drive(m, 3'b111, 4'b0000);
    @(negedge clk); drive(3'b000, 3'b000, 4'b0000);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 pend", pend_id, 0); chk("R1 top", top_src, 0); chk("R1 irq", irq, 0);
    @(negedge clk); rst_n = 1;
    for (int m = 0; m < 8; m++)
      for (int ev = 0; ev < 8; ev++)
        for (int en = 0; en < 8; en++)
          for (int st = 0; st < 16; st++) begin
            logic [2:0] s, c, e;
            load(m[2:0]);
            chk("R1 load", pend_id, m);
            drive(ev[2:0], en[2:0], st[3:0]);
            s = ev[2:0] & en[2:0];
            c = {st[3], st[2], st[1] | st[0]};
            e = s | (m[2:0] & ~c);
            @(negedge clk);
            if (ev[2] && en[2] && st[3]) chk("R6 set beats clear", pend_id, e);
            else if (!en[2]) chk("R7 masked event", pend_id[2], m[2] & ~st[3]);
            chk("R2 R3 R4 R5 mask", pend_id, e);
            drive(3'b000, en[2:0], 4'b0000);
            #1;
            chk("R8 irq", irq, |(e & en[2:0]));
            chk("R9 top", top_src, prio(e));
          end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule